// File: doc/BRIEF.md
# Command-Response Buffer Control Block

This block is the host-facing register front end of a trusted-module command channel. A host bus reads and writes it with accesses of one to four bytes, packed little-endian. Each access carries a byte address. The register half of the map holds several things:

- the locality ownership state;
- the idle and ready control;
- a start doorbell and a cancel doorbell;
- fixed identification words;
- the size and address words that describe a shared data window.

The other half of the map is that data window, a small byte RAM. The host places a command there and later collects the response from it.

When the owning locality rings the start doorbell, the block reads the command size from the buffer header and clamps it to the backend capacity. It then emits a one-cycle request to a backend port, with that length and the fixed response capacity. The command stays pending until the backend reports completion with a status. A cancel pulse can be sent to the backend only while a command is pending.

Two small state machines hold the behaviour:

- **Locality machine.** States are `LOC_FREE` and `LOC_HELD`. The transition REQUEST (locality-control value 1) moves it to `LOC_HELD`. The transition RELEASE (value 2) moves it back to `LOC_FREE`.
- **Command machine.** States are `CMD_WAIT` and `CMD_PEND`. The transition ACCEPT (a valid start) moves it to `CMD_PEND`. The transition COMPLETE (backend done) moves it back to `CMD_WAIT`.

Top module: `cmdbuf_ctl`

## Requirements

- R1: After reset, these registers read as follows:
  - locality-state (offset 0x000) reads 0x80, with the register-valid bit at bit 7, when the established input is high;
  - control-status (0x044) reads 0x2, with idle at bit 1 and fatal at bit 0;
  - interface-ID (0x030) reads 0x00025811: type 1 in bits 3:0, version 1 in bits 7:4, transfer-size code 3 in bits 12:11, buffer-interface-supported at bit 14, selector 1 in bits 18:17, and all other fields 0;
  - command-size (0x058) and response-size (0x064) read as the buffer size in bytes;
  - command-address (0x05C) and response-address (0x068) read as BASE_ADDR plus the window offset 0x8000;
  - start (0x04C) and locality-status (0x00C) read 0.
- R2: A read returns the 32-bit word at the word-aligned address, shifted right by 8 times the low two address bits.
- R3: A write to control-request (0x040) with the value exactly 1 clears idle, and with exactly 2 sets idle. Any other value leaves idle unchanged.
- R4: A write to locality-control (0x008) behaves as follows:
  - the value 1 sets both locality-assigned (locality-state bit 1) and granted (locality-status bit 0), and clears been-seized (locality-status bit 1);
  - the value 2 clears assigned and granted;
  - any other value, including 8, has no effect.
- R5: While no locality is assigned, the active locality is the no-locality code 0xFF, so no start is accepted. While one is assigned, the active locality is 0.
- R6: A write of exactly 1 to start is accepted only when start bit 0 is clear and the write's locality (address bits 14:12) equals the active locality. On acceptance, start bit 0 reads 1 and `be_req` is high for the one cycle after the write.
- R7: `be_len` is the big-endian 32-bit size held in buffer bytes 2 to 5, clamped to min(BE_BYTES, BUF_BYTES).
- R8: A write of exactly 1 to cancel (0x048) raises `be_cancel` for one cycle only while start bit 0 is set. Any other cancel write does nothing.
- R9: `be_done` while a command is pending clears start bit 0. If `be_status` is nonzero, fatal (control-status bit 0) is also set and it stays set until reset. `be_done` with no command pending has no effect.
- R10: Bit 0 of the locality-state word is the inverse of `be_established`.
- R11: Addresses with bit 15 set access the data RAM. Writes store 1 to 4 bytes little-endian, and reads return 4 bytes little-endian.
- R12: `be_cap` equals min(BE_BYTES, BUF_BYTES).

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address; bit 15 selects the data RAM, bits 14:12 give the locality |
| bus_wr | input | 1 | Write strobe |
| bus_len | input | 2 | Access length in bytes, minus one |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data for bus_addr |
| be_req | output | 1 | One-cycle command request to the backend |
| be_len | output | 32 | Clamped command length |
| be_cap | output | 32 | Response capacity |
| be_cancel | output | 1 | One-cycle cancel pulse |
| be_done | input | 1 | Backend completion |
| be_status | input | ST_W | Completion status; nonzero means error |
| be_established | input | 1 | Backend established flag |

## Verification

The start path is swept over all eight localities. It is repeated under command sizes below, at and above the clamp limit, and at the all-ones value. This separates a wrong locality compare, a wrong byte order in the header and an off-by-one clamp.

The control-request and locality-control registers each get every value from 0 to 15. This distinguishes decoding of the exact value from decoding of a single bit.

Starts and cancels are also sent while a command is already pending and while nothing is pending, which separates the guard on each doorbell. Completions with zero and nonzero status, and a stray completion with nothing pending, separate the setting of fatal from its guard.

// File: rtl/cmdbuf_pkg.sv
`timescale 1ns/1ps
package cmdbuf_pkg;
    localparam logic [11:0] OFF_LOC_STATE = 12'h000;
    localparam logic [11:0] OFF_LOC_CTRL  = 12'h008;
    localparam logic [11:0] OFF_LOC_STS   = 12'h00C;
    localparam logic [11:0] OFF_INTF_ID   = 12'h030;
    localparam logic [11:0] OFF_CTRL_REQ  = 12'h040;
    localparam logic [11:0] OFF_CTRL_STS  = 12'h044;
    localparam logic [11:0] OFF_CANCEL    = 12'h048;
    localparam logic [11:0] OFF_START     = 12'h04C;
    localparam logic [11:0] OFF_CMD_SIZE  = 12'h058;
    localparam logic [11:0] OFF_CMD_ADDR  = 12'h05C;
    localparam logic [11:0] OFF_RSP_SIZE  = 12'h064;
    localparam logic [11:0] OFF_RSP_ADDR  = 12'h068;

    localparam logic [31:0] LOC_CMD_REQUEST = 32'd1;
    localparam logic [31:0] LOC_CMD_RELEASE = 32'd2;
    localparam logic [31:0] REQ_CMD_READY   = 32'd1;
    localparam logic [31:0] REQ_CMD_IDLE    = 32'd2;
    localparam logic [31:0] DOORBELL_RING   = 32'd1;

    localparam logic [7:0] NO_LOCALITY  = 8'hFF;
    localparam logic [7:0] ACTIVE_FIELD = 8'h00;

    localparam logic [31:0] ID_TYPE    = 32'd1;
    localparam logic [31:0] ID_VERSION = 32'd1;
    localparam logic [31:0] ID_XFER    = 32'd3;
    localparam logic [31:0] ID_BUFIF   = 32'd1;
    localparam logic [31:0] ID_SELECT  = 32'd1;
    localparam logic [31:0] INTF_ID_WORD = ID_TYPE | (ID_VERSION << 4) |
        (ID_XFER << 11) | (ID_BUFIF << 14) | (ID_SELECT << 17);

    typedef enum logic { LOC_FREE, LOC_HELD } loc_state_e;
    typedef enum logic { CMD_WAIT, CMD_PEND } cmd_state_e;
endpackage

// File: rtl/cmdbuf_loc.sv
`timescale 1ns/1ps
module cmdbuf_loc
    import cmdbuf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_wr,
    input  logic [31:0] ctl_val,
    output logic        held,
    output logic        granted,
    output logic        seized,
    output logic [7:0]  active_id
);
    loc_state_e state_q, state_d;
    logic       seized_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LOC_FREE: if (ctl_wr && ctl_val == LOC_CMD_REQUEST) state_d = LOC_HELD;
            LOC_HELD: if (ctl_wr && ctl_val == LOC_CMD_RELEASE) state_d = LOC_FREE;
            default:  state_d = LOC_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LOC_FREE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            seized_q <= 1'b0;
        else if (ctl_wr && ctl_val == LOC_CMD_REQUEST)
            seized_q <= 1'b0;
    end

    assign held      = (state_q == LOC_HELD);
    assign granted   = held;
    assign seized    = seized_q;
    assign active_id = held ? ACTIVE_FIELD : NO_LOCALITY;

    // R4
    loc_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_val == LOC_CMD_REQUEST) |=> (held && granted && !seized));
    // R4
    loc_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_val == LOC_CMD_RELEASE) |=> (!held && !granted));
    // R4
    loc_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ctl_wr && (ctl_val == LOC_CMD_REQUEST || ctl_val == LOC_CMD_RELEASE)))
        |=> $stable(held));
endmodule

// File: rtl/cmdbuf_cmd.sv
`timescale 1ns/1ps
module cmdbuf_cmd
    import cmdbuf_pkg::*;
#(
    parameter int          ST_W = 8,
    parameter logic [31:0] EFF  = 32'd48
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_wr,
    input  logic            cancel_wr,
    input  logic            req_wr,
    input  logic [31:0]     wval,
    input  logic [7:0]      wr_loc,
    input  logic [7:0]      active_id,
    input  logic [31:0]     hdr_size,
    input  logic            be_done,
    input  logic [ST_W-1:0] be_status,
    output logic            pending,
    output logic            idle,
    output logic            fatal,
    output logic            be_req,
    output logic [31:0]     be_len,
    output logic            be_cancel
);
    cmd_state_e state_q, state_d;
    logic       accept;

    assign accept = start_wr && wval == DOORBELL_RING &&
                    state_q == CMD_WAIT && wr_loc == active_id;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMD_WAIT: if (accept)  state_d = CMD_PEND;
            CMD_PEND: if (be_done) state_d = CMD_WAIT;
            default:  state_d = CMD_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CMD_WAIT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            be_req    <= 1'b0;
            be_len    <= '0;
            be_cancel <= 1'b0;
            idle      <= 1'b1;
            fatal     <= 1'b0;
        end else begin
            be_req    <= accept;
            be_cancel <= cancel_wr && wval == DOORBELL_RING && state_q == CMD_PEND;
            if (accept)
                be_len <= (hdr_size > EFF) ? EFF : hdr_size;
            if (req_wr && wval == REQ_CMD_READY)
                idle <= 1'b0;
            else if (req_wr && wval == REQ_CMD_IDLE)
                idle <= 1'b1;
            if (state_q == CMD_PEND && be_done && be_status != '0)
                fatal <= 1'b1;
        end
    end

    assign pending = (state_q == CMD_PEND);

    // R6
    req_locality_chk: assert property (@(posedge clk) disable iff (!rst_n)
        be_req |-> ($past(start_wr) && $past(wr_loc) == $past(active_id)));
    // R6
    req_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        be_req |-> pending);
    // R7
    len_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        be_req |-> (be_len <= EFF));
    // R8
    cancel_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        be_cancel |-> $past(pending));
    // R9
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && be_done) |=> !pending);
    // R9
    fatal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fatal) |-> fatal);
endmodule

// File: rtl/cmdbuf_ram.sv
`timescale 1ns/1ps
module cmdbuf_ram #(
    parameter int BYTES = 64,
    parameter int AW    = $clog2(BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [1:0]    len,
    input  logic [31:0]   wdata,
    output logic [31:0]   rword,
    output logic [31:0]   hdr_size
);
    logic [7:0] mem [BYTES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < BYTES; i++) mem[i] <= 8'h00;
        end else if (wr) begin
            for (int i = 0; i < 4; i++)
                if (2'(i) <= len) mem[AW'(addr + AW'(i))] <= wdata[8*i +: 8];
        end
    end

    for (genvar g = 0; g < 4; g++) begin : g_lane
        assign rword[8*g +: 8] = mem[AW'(addr + AW'(g))];
    end

    assign hdr_size = {mem[2], mem[3], mem[4], mem[5]};
endmodule

// File: rtl/cmdbuf_ctl.sv
`timescale 1ns/1ps
module cmdbuf_ctl
    import cmdbuf_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          BUF_BYTES = 64,
    parameter int          BE_BYTES  = 48,
    parameter int          ST_W      = 8,
    parameter logic [31:0] BASE_ADDR = 32'h1000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [1:0]        bus_len,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              be_req,
    output logic [31:0]       be_len,
    output logic [31:0]       be_cap,
    output logic              be_cancel,
    input  logic              be_done,
    input  logic [ST_W-1:0]   be_status,
    input  logic              be_established
);
    localparam int          BUF_AW  = $clog2(BUF_BYTES);
    localparam int          LOC_W   = ADDR_W - 13;
    localparam logic [31:0] EFF     = (BE_BYTES < BUF_BYTES) ? 32'(BE_BYTES) : 32'(BUF_BYTES);
    localparam logic [31:0] WIN_OFF = 32'(1) << (ADDR_W - 1);

    logic        reg_sel, reg_wr;
    logic [11:0] off;
    logic [7:0]  wr_loc;
    logic [31:0] wmask, wval, ram_word, hdr_size, word;
    logic        held, granted, seized, pending, idle, fatal;
    logic [7:0]  active_id;

    assign reg_sel = !bus_addr[ADDR_W-1];
    assign reg_wr  = bus_wr && reg_sel;
    assign off     = bus_addr[11:0];
    assign wr_loc  = 8'(bus_addr[ADDR_W-2 -: LOC_W]);

    always_comb begin
        unique case (bus_len)
            2'd0: wmask = 32'h0000_00FF;
            2'd1: wmask = 32'h0000_FFFF;
            2'd2: wmask = 32'h00FF_FFFF;
            default: wmask = 32'hFFFF_FFFF;
        endcase
    end
    assign wval = bus_wdata & wmask;

    cmdbuf_loc u_loc (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (reg_wr && off == OFF_LOC_CTRL),
        .ctl_val   (wval),
        .held      (held),
        .granted   (granted),
        .seized    (seized),
        .active_id (active_id)
    );

    cmdbuf_cmd #(.ST_W(ST_W), .EFF(EFF)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_wr  (reg_wr && off == OFF_START),
        .cancel_wr (reg_wr && off == OFF_CANCEL),
        .req_wr    (reg_wr && off == OFF_CTRL_REQ),
        .wval      (wval),
        .wr_loc    (wr_loc),
        .active_id (active_id),
        .hdr_size  (hdr_size),
        .be_done   (be_done),
        .be_status (be_status),
        .pending   (pending),
        .idle      (idle),
        .fatal     (fatal),
        .be_req    (be_req),
        .be_len    (be_len),
        .be_cancel (be_cancel)
    );

    cmdbuf_ram #(.BYTES(BUF_BYTES), .AW(BUF_AW)) u_ram (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr && !reg_sel),
        .addr     (bus_addr[BUF_AW-1:0]),
        .len      (bus_len),
        .wdata    (bus_wdata),
        .rword    (ram_word),
        .hdr_size (hdr_size)
    );

    always_comb begin
        word = '0;
        unique case ({off[11:2], 2'b00})
            OFF_LOC_STATE: word = {24'd0, 1'b1, 2'b00, ACTIVE_FIELD[2:0], held, !be_established};
            OFF_LOC_STS:   word = {30'd0, seized, granted};
            OFF_INTF_ID:   word = INTF_ID_WORD;
            OFF_CTRL_STS:  word = {30'd0, idle, fatal};
            OFF_START:     word = {31'd0, pending};
            OFF_CMD_SIZE,
            OFF_RSP_SIZE:  word = 32'(BUF_BYTES);
            OFF_CMD_ADDR,
            OFF_RSP_ADDR:  word = BASE_ADDR + WIN_OFF;
            default:       word = '0;
        endcase
    end

    assign bus_rdata = reg_sel ? (word >> {bus_addr[1:0], 3'b000}) : ram_word;
    assign be_cap    = EFF;
endmodule

// File: tb/cmdbuf_ctl_tb_top.sv
`timescale 1ns/1ps
module cmdbuf_ctl_tb_top;
    localparam logic [31:0] BASE = 32'h1000_0000;
    localparam int          CAP  = 48;
    localparam logic [15:0] WIN  = 16'h8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_len = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        be_req, be_cancel;
    logic [31:0] be_len, be_cap;
    logic        be_done = 1'b0;
    logic [7:0]  be_status = '0;
    logic        be_established = 1'b1;

    int nchk = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    cmdbuf_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_len(bus_len), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .be_req(be_req), .be_len(be_len), .be_cap(be_cap), .be_cancel(be_cancel),
        .be_done(be_done), .be_status(be_status), .be_established(be_established)
    );

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s got 0x%08h exp 0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [1:0] l, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_len = l; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic done(input logic [7:0] st);
        @(negedge clk);
        be_done = 1'b1; be_status = st;
        @(negedge clk);
        be_done = 1'b0; be_status = '0;
    endtask

    initial begin
        #4000000;
        nfail++;
        $display("FAIL R6 watchdog got 0x0 exp 0x1");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic        idle_m, held_m;
        logic [31:0] sizes [8];
        sizes = '{32'd0, 32'd5, 32'd47, 32'd48, 32'd49, 32'd64, 32'h0100_0000, 32'hFFFF_FFFF};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(16'h000, d); check(d, 32'h80, "R1 loc_state");
        rd(16'h044, d); check(d, 32'h2, "R1 ctrl_sts");
        rd(16'h030, d); check(d, 32'h0002_5811, "R1 intf_id");
        rd(16'h058, d); check(d, 32'd64, "R1 cmd_size");
        rd(16'h064, d); check(d, 32'd64, "R1 rsp_size");
        rd(16'h05C, d); check(d, BASE + 32'h8000, "R1 cmd_addr");
        rd(16'h068, d); check(d, BASE + 32'h8000, "R1 rsp_addr");
        rd(16'h04C, d); check(d, 32'h0, "R1 start");
        rd(16'h00C, d); check(d, 32'h0, "R1 loc_sts");
        check(32'(be_req), 32'h0, "R1 be_req");
        // R12 capacity
        check(be_cap, CAP, "R12 be_cap");

        // R2 byte-shifted reads
        for (int i = 0; i < 4; i++) begin
            rd(16'h030 + 16'(i), d);
            check(d, 32'h0002_5811 >> (8 * i), "R2 shift");
        end

        // R10 established flag
        be_established = 1'b0;
        rd(16'h000, d); check(d, 32'h81, "R10 est low");
        be_established = 1'b1;
        rd(16'h000, d); check(d, 32'h80, "R10 est high");

        // R3 control-request sweep
        idle_m = 1'b1;
        for (int v = 0; v < 16; v++) begin
            wr(16'h040, 2'd3, 32'(v));
            if (v == 1) idle_m = 1'b0;
            else if (v == 2) idle_m = 1'b1;
            rd(16'h044, d); check(d, {30'd0, idle_m, 1'b0}, "R3 idle");
        end

        // R5 start with nothing assigned is rejected
        wr(16'h04C, 2'd3, 32'd1);
        check(32'(be_req), 32'h0, "R5 no locality be_req");
        rd(16'h04C, d); check(d, 32'h0, "R5 no locality start");

        // R4 locality-control sweep
        held_m = 1'b0;
        for (int v = 0; v < 16; v++) begin
            wr(16'h008, 2'd3, 32'(v));
            if (v == 1) held_m = 1'b1;
            else if (v == 2) held_m = 1'b0;
            rd(16'h000, d); check(d, {24'd0, 1'b1, 5'd0, held_m, 1'b0}, "R4 assigned");
            rd(16'h00C, d); check(d, {31'd0, held_m}, "R4 granted");
        end
        wr(16'h008, 2'd3, 32'd1);

        // R8 cancel while idle is ignored
        wr(16'h048, 2'd3, 32'd1);
        check(32'(be_cancel), 32'h0, "R8 cancel idle");

        // R9 stray completion
        done(8'h05);
        rd(16'h044, d); check(d & 32'h1, 32'h0, "R9 stray done");

        // R6/R7/R8/R9 size and locality sweep
        foreach (sizes[k]) begin
            logic [31:0] sz;
            sz = sizes[k];
            wr(WIN | 16'h2, 2'd3, {sz[7:0], sz[15:8], sz[23:16], sz[31:24]});
            // R11 buffer readback
            rd(WIN | 16'h2, d); check(d, {sz[7:0], sz[15:8], sz[23:16], sz[31:24]}, "R11 buf word");
            rd(WIN | 16'h3, d); check(d & 32'hFF, 32'(sz[23:16]), "R11 buf byte");
            for (int l = 7; l >= 0; l--) begin
                wr(16'(l << 12) | 16'h04C, 2'd3, 32'd1);
                if (l != 0) begin
                    check(32'(be_req), 32'h0, "R6 wrong locality");
                end else begin
                    check(32'(be_req), 32'h1, "R6 accepted");
                    check(be_len, (sz > CAP) ? CAP : sz, "R7 clamp");
                end
            end
            rd(16'h04C, d); check(d, 32'h1, "R6 start bit");
            wr(16'h04C, 2'd3, 32'd1);
            check(32'(be_req), 32'h0, "R6 pending reject");
            wr(16'h048, 2'd3, 32'd3);
            check(32'(be_cancel), 32'h0, "R8 cancel value");
            wr(16'h048, 2'd3, 32'd1);
            check(32'(be_cancel), 32'h1, "R8 cancel pulse");
            done(8'h00);
            rd(16'h04C, d); check(d, 32'h0, "R9 start cleared");
            rd(16'h044, d); check(d & 32'h1, 32'h0, "R9 ok status");
        end

        // R11 partial byte write
        wr(WIN | 16'h10, 2'd3, 32'h0);
        wr(WIN | 16'h11, 2'd1, 32'hA5C3);
        rd(WIN | 16'h10, d); check(d, 32'h00A5_C300, "R11 two-byte write");

        // R9 error status sets fatal
        wr(16'h04C, 2'd3, 32'd1);
        done(8'h07);
        rd(16'h044, d); check(d & 32'h1, 32'h1, "R9 fatal");

        // R5 relinquish then start rejected
        wr(16'h008, 2'd3, 32'd2);
        wr(16'h04C, 2'd3, 32'd1);
        check(32'(be_req), 32'h0, "R5 relinquished");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end
endmodule